// File: doc/BRIEF.md
# SPI Master/Slave Serial Port

This block is a byte-wide synchronous serial port with a small register interface. It runs either as an SPI master, producing the serial clock itself, or as an SPI slave clocked from outside. A CPU writes the byte to send into the buffer address. In master mode that write also starts the transfer. The received byte lands in the same buffer address for reading. Data is shifted most-significant bit first through an 8-bit shift path. A completed byte raises a buffer-full flag and a one-cycle interrupt pulse.

In master mode the serial clock comes from the system clock divided by 4, 16 or 64, or from an external timer tick divided by 2. The mode field selects the source. In slave mode the serial clock is taken from a pin and resynchronised to the system clock. An optional slave-select input can gate the slave: while select is high, the shift logic is held in reset and the data output driver is released. Polarity and edge selection are taken from the control and status registers. Write-collision and receive-overflow are flagged in the control register.

Top module: `spi_serial_port`

## Requirements
- R1: After reset, the control register (address 1) and status register (address 2) read 0x00, `sck_o` is low, and `sdo_oe` and `irq_o` are low.
- R2: While the enable bit (control bit 5) is 0, a buffer write causes no serial clock, no completion and no interrupt. `sck_oe` and `sdo_oe` stay low.
- R3: The mode field is control bits 3:0. Codes 0000, 0001 and 0010 give a master serial clock period of 4, 16 and 64 system clocks. Code 0011 gives a period of two `tmr_tick` pulses. Codes 0100 and 0101 are slave modes. Every other code behaves as disabled.
- R4: Bytes are sent and received MSB first. In master loopback (`sdi` tied to `sdo`) the received byte equals the sent byte for all four combinations of the sample-phase bit (status bit 7) and the clock-edge bit (status bit 6).
- R5: The serial clock idles at the polarity bit (control bit 4). In master mode each byte produces exactly 8 edges leaving the idle level, and the clock is back at idle when the byte completes.
- R6: Completing a byte sets buffer-full (status bit 0) and pulses `irq_o` for one cycle in the same cycle. Reading address 0 with `rd_en` clears buffer-full.
- R7: If a byte completes while buffer-full is set, the overflow flag (control bit 6) sets and the buffer keeps the older byte.
- R8: A buffer write during an active transfer sets the write-collision flag (control bit 7) and is ignored. Both flags clear when software writes 0 to them through the control register.
- R9: In slave mode 0101 with clock-edge bit 0, the port shifts out the written byte and captures `sdi` on the external clock.
- R10: In slave mode 0100, a high `sel_n` drops `sdo_oe` and resets the shift logic. A buffer write afterwards is accepted without collision, and the next transfer starts from bit 7.
- R11: Slave mode 0101 with clock-edge bit 1 is unsupported and behaves as disabled: `sdo_oe` stays low and external clocks complete no byte.
- R12: Status bits 7 and 6 are writable. Status bits 5:1 and address 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (instruction) clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears buffer-full at address 0) |
| addr | input | 2 | Register address: 0 buffer, 1 control, 2 status |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (combinational) |
| tmr_tick | input | 1 | One-cycle timer pulse for the timer clock source |
| sck_i | input | 1 | Serial clock from the pin (slave) |
| sck_o | output | 1 | Serial clock to the pin (master) |
| sck_oe | output | 1 | Serial clock driver enable (master) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output driver enable |
| sel_n | input | 1 | Slave select, active low |
| irq_o | output | 1 | One-cycle completion pulse |

## Verification
A register write is visible to a read in the next cycle. A master transfer starts one cycle after the buffer write. Its first clock edge follows one half period later. Buffer-full and `irq_o` rise together two cycles after the final internal clock event. Slave clock and select edges reach the shift logic about three system clocks late because of the synchroniser. The bench therefore avoids exact-cycle sampling around serial events: it waits for the interrupt with a bounded timeout, holds each external clock half period for eight cycles and changes `sdi` six cycles after an edge. It samples every register and pin on the falling system clock edge, away from the update edge.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int DATA_W   = 8;
    localparam int DIV_FAST = 4;
    localparam int DIV_MID  = 16;
    localparam int DIV_SLOW = 64;

    localparam logic [1:0] ADDR_BUF  = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    typedef enum logic [1:0] {
        CLK_FAST = 2'd0,
        CLK_MID  = 2'd1,
        CLK_SLOW = 2'd2,
        CLK_TMR  = 2'd3
    } clk_src_e;

    typedef struct packed {
        logic     valid;
        logic     master;
        logic     ss_ctl;
        clk_src_e src;
    } mode_t;

    function automatic mode_t decode_mode(input logic [3:0] code);
        mode_t r;
        r = '0;
        case (code)
            4'b0000: begin r.valid = 1'b1; r.master = 1'b1; r.src = CLK_FAST; end
            4'b0001: begin r.valid = 1'b1; r.master = 1'b1; r.src = CLK_MID;  end
            4'b0010: begin r.valid = 1'b1; r.master = 1'b1; r.src = CLK_SLOW; end
            4'b0011: begin r.valid = 1'b1; r.master = 1'b1; r.src = CLK_TMR;  end
            4'b0100: begin r.valid = 1'b1; r.ss_ctl = 1'b1; end
            4'b0101: begin r.valid = 1'b1; end
            default: ;
        endcase
        return r;
    endfunction

    function automatic int half_limit(input clk_src_e s);
        case (s)
            CLK_FAST: return DIV_FAST / 2 - 1;
            CLK_MID:  return DIV_MID / 2 - 1;
            CLK_SLOW: return DIV_SLOW / 2 - 1;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/spi_sck_div.sv
module spi_sck_div
    import spi_port_pkg::*;
#(
    parameter int CNT_W = $clog2(DIV_SLOW / 2)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  clk_src_e src,
    input  logic     tmr_tick,
    output logic     evt
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    always_comb lim = CNT_W'(half_limit(src));

    always_comb evt = run && ((src == CLK_TMR) ? tmr_tick : (cnt == lim));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (src != CLK_TMR) begin
            cnt <= (cnt == lim) ? '0 : cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int W  = 8,
    localparam int EW = $clog2(2 * W + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         evt,
    input  logic         is_master,
    input  logic         cke,
    input  logic         smp,
    input  logic         sdi,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         start,
    output logic         sck_active,
    output logic         sdo,
    output logic         xfer,
    output logic         done,
    output logic [W-1:0] rx_byte
);

    logic [EW-1:0] ec;
    logic [EW-1:0] base;
    logic [EW-1:0] rel;
    logic [EW-1:0] last_smp;
    logic [EW-1:0] end_ec;
    logic [W-1:0]  tx_sr;
    logic [W-1:0]  rx_sr;
    logic          take;
    logic          smp_hit;
    logic          shift_hit;
    logic          fin;

    always_comb begin
        base = '0;
        if (!cke)              base = base + EW'(1);
        if (is_master && smp)  base = base + EW'(1);
        last_smp  = base + EW'(2 * (W - 1));
        end_ec    = (last_smp > EW'(2 * W - 1)) ? last_smp : EW'(2 * W - 1);
        rel       = ec - base;
        take      = evt && (xfer || !is_master);
        smp_hit   = take && (ec >= base) && !rel[0];
        shift_hit = take && (ec != '0) && (ec[0] == cke) && (ec < EW'(2 * W));
        fin       = take && (ec == end_ec);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= load_data;
        end else if (shift_hit && !clr) begin
            tx_sr <= {tx_sr[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ec         <= '0;
            xfer       <= 1'b0;
            sck_active <= 1'b0;
            done       <= 1'b0;
            rx_sr      <= '0;
        end else if (clr) begin
            ec         <= '0;
            xfer       <= 1'b0;
            sck_active <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                xfer       <= 1'b1;
                ec         <= '0;
                sck_active <= 1'b0;
            end else if (take) begin
                xfer <= 1'b1;
                ec   <= ec + EW'(1);
                if (is_master && (ec < EW'(2 * W))) sck_active <= ~sck_active;
                if (smp_hit) rx_sr <= {rx_sr[W-2:0], sdi};
                if (fin) begin
                    xfer <= 1'b0;
                    ec   <= '0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign sdo     = tx_sr[W-1];
    assign rx_byte = rx_sr;

endmodule

// File: rtl/spi_serial_port.sv
module spi_serial_port
    import spi_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       tmr_tick,
    input  logic       sck_i,
    output logic       sck_o,
    output logic       sck_oe,
    input  logic       sdi,
    output logic       sdo,
    output logic       sdo_oe,
    input  logic       sel_n,
    output logic       irq_o
);

    logic             wcol_q, ovf_q, en_q, ckp_q;
    logic [3:0]       mode_q;
    logic             smp_q, cke_q, bf_q;
    logic [DATA_W-1:0] rx_buf;
    logic             irq_q;
    mode_t            md;
    logic             active, gate, clr;
    logic             buf_wr, accept, wcol_set, start;
    logic             sel_s1, sel_s;
    logic [2:0]       sck_s;
    logic             m_evt, s_evt, evt;
    logic             sck_active, xfer, done;
    logic [DATA_W-1:0] rx_byte;

    always_comb begin
        md       = decode_mode(mode_q);
        active   = en_q && md.valid && !(!md.master && cke_q && !md.ss_ctl);
        gate     = md.ss_ctl && sel_s;
        clr      = !active || gate;
        buf_wr   = wr_en && (addr == ADDR_BUF);
        accept   = buf_wr && active && !xfer;
        wcol_set = buf_wr && active && xfer;
        start    = accept && md.master;
        s_evt    = active && !md.master && (sck_s[1] ^ sck_s[2]);
        evt      = md.master ? m_evt : s_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_s1 <= 1'b1;
            sel_s  <= 1'b1;
            sck_s  <= '0;
        end else begin
            sel_s1 <= sel_n;
            sel_s  <= sel_s1;
            sck_s  <= {sck_s[1:0], sck_i};
        end
    end

    spi_sck_div u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (xfer && md.master && active),
        .src      (md.src),
        .tmr_tick (tmr_tick),
        .evt      (m_evt)
    );

    spi_shift_engine #(.W(DATA_W)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .evt        (evt),
        .is_master  (md.master),
        .cke        (cke_q),
        .smp        (smp_q),
        .sdi        (sdi),
        .load       (accept),
        .load_data  (wr_data),
        .start      (start),
        .sck_active (sck_active),
        .sdo        (sdo),
        .xfer       (xfer),
        .done       (done),
        .rx_byte    (rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            {wcol_q, ovf_q, en_q, ckp_q, mode_q} <= '0;
            smp_q  <= 1'b0;
            cke_q  <= 1'b0;
            bf_q   <= 1'b0;
            rx_buf <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= done;
            if (wr_en && (addr == ADDR_CTRL)) begin
                {wcol_q, ovf_q, en_q, ckp_q, mode_q} <= wr_data;
            end
            if (wr_en && (addr == ADDR_STAT)) begin
                smp_q <= wr_data[7];
                cke_q <= wr_data[6];
            end
            if (wcol_set) wcol_q <= 1'b1;
            if (rd_en && (addr == ADDR_BUF)) bf_q <= 1'b0;
            if (done) begin
                if (bf_q) begin
                    ovf_q <= 1'b1;
                end else begin
                    rx_buf <= rx_byte;
                    bf_q   <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        case (addr)
            ADDR_BUF:  rd_data = rx_buf;
            ADDR_CTRL: rd_data = {wcol_q, ovf_q, en_q, ckp_q, mode_q};
            ADDR_STAT: rd_data = {smp_q, cke_q, 5'b00000, bf_q};
            default:   rd_data = '0;
        endcase
    end

    assign sck_o  = ckp_q ^ (md.master & sck_active);
    assign sck_oe = active && md.master;
    assign sdo_oe = active && !(md.ss_ctl && sel_n);
    assign irq_o  = irq_q;

endmodule

// File: rtl/spi_serial_port_chk.sv
module spi_serial_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       ckp,
    input logic       gate,
    input logic       xfer,
    input logic       bf,
    input logic       rd_en,
    input logic [1:0] addr,
    input logic       irq_o,
    input logic [7:0] rx_buf,
    input logic       sck_o,
    input logic       sck_oe,
    input logic       sdo_oe
);

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!sck_oe && !sdo_oe));                                   // R2

    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (rst)
        (sck_oe && !xfer) |-> (sck_o == ckp));                           // R5

    AST_IRQ_WITH_BF: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> bf);                                                   // R6

    AST_BF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (bf && !(rd_en && addr == 2'd0)) |=> bf);                        // R6

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        (irq_o && $past(bf)) |-> $stable(rx_buf));                       // R7

    AST_SEL_RESETS: assert property (@(posedge clk) disable iff (rst)
        gate |=> !xfer);                                                 // R10

endmodule

bind spi_serial_port spi_serial_port_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (en_q),
    .ckp    (ckp_q),
    .gate   (gate),
    .xfer   (xfer),
    .bf     (bf_q),
    .rd_en  (rd_en),
    .addr   (addr),
    .irq_o  (irq_o),
    .rx_buf (rx_buf),
    .sck_o  (sck_o),
    .sck_oe (sck_oe),
    .sdo_oe (sdo_oe)
);

// File: tb/spi_serial_port_tb.sv
module spi_serial_port_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       tmr_tick = 1'b0;
    logic       sck_i = 1'b0;
    logic       sck_o, sck_oe, sdo, sdo_oe, irq_o;
    logic       sdi;
    logic       sdi_drv = 1'b0;
    logic       loop_en = 1'b1;
    logic       sel_n = 1'b1;

    int checks = 0, errors = 0;
    int cyc = 0, irq_cnt = 0, lead_cnt = 0, last_lead = 0, period = 0, tcnt = 0;
    logic cur_ckp = 1'b0, sck_prev = 1'b0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign sdi = loop_en ? sdo : sdi_drv;

    spi_serial_port u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .tmr_tick(tmr_tick),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo),
        .sdo_oe(sdo_oe), .sel_n(sel_n), .irq_o(irq_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (irq_o) irq_cnt <= irq_cnt + 1;
    end

    always @(negedge clk) begin
        if (tcnt == 4) begin tmr_tick <= 1'b1; tcnt <= 0; end
        else begin tmr_tick <= 1'b0; tcnt <= tcnt + 1; end
        if (sck_o != sck_prev && sck_o != cur_ckp) begin
            lead_cnt  <= lead_cnt + 1;
            period    <= cyc - last_lead;
            last_lead <= cyc;
        end
        sck_prev <= sck_o;
    end

    function automatic int exp_period(input logic [3:0] m);
        case (m)
            4'b0000: return 4;
            4'b0001: return 16;
            4'b0010: return 64;
            default: return 10;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wait_irq(input int base, input int maxc, output bit ok);
        ok = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (irq_cnt != base) begin ok = 1; break; end
        end
    endtask

    task automatic cfg(input logic [3:0] m, input logic ckp, input logic cke, input logic smp);
        cur_ckp = ckp;
        wr(2'd1, {3'b000, ckp, m});
        wr(2'd2, {smp, cke, 6'b0});
        wr(2'd1, {3'b001, ckp, m});
        repeat (2) @(negedge clk);
    endtask

    task automatic m_xfer(input logic [3:0] m, input logic ckp, input logic cke,
                          input logic smp, input logic [7:0] tx, input string tag);
        logic [7:0] r; bit ok; int b, l0;
        loop_en = 1'b1;
        cfg(m, ckp, cke, smp);
        b = irq_cnt; l0 = lead_cnt;
        wr(2'd0, tx);
        wait_irq(b, 2000, ok);
        chk({tag, " R6 irq seen"}, ok, 1);
        repeat (2) @(negedge clk);
        chk({tag, " R5 leading edges"}, lead_cnt - l0, 8);
        chk({tag, " R5 idle level"}, sck_o, ckp);
        chk({tag, " R3 period"}, period, exp_period(m));
        rd(2'd2, r); chk({tag, " R6 bf set"}, r[0], 1);
        rd(2'd0, r); chk({tag, " R4 loopback data"}, r, tx);
        rd(2'd2, r); chk({tag, " R6 bf cleared"}, r[0], 0);
    endtask

    task automatic bang(input logic ckp, input logic cke, input logic [7:0] rxb,
                        input int nbits, output logic [7:0] got);
        got = 8'd0;
        for (int i = 0; i < nbits; i++) begin
            sdi_drv = rxb[7 - i];
            repeat (4) @(negedge clk);
            if (cke) got = {got[6:0], sdo};
            sck_i = ~ckp;
            repeat (8) @(negedge clk);
            if (!cke) got = {got[6:0], sdo};
            sck_i = ckp;
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic s_xfer(input logic [3:0] m, input logic ckp, input logic cke,
                          input logic [7:0] txb, input logic [7:0] rxb, input string tag);
        logic [7:0] got, r; bit ok; int b;
        loop_en = 1'b0; sck_i = ckp; sel_n = 1'b0;
        cfg(m, ckp, cke, 1'b0);
        wr(2'd0, txb);
        b = irq_cnt;
        bang(ckp, cke, rxb, 8, got);
        wait_irq(b, 50, ok);
        chk({tag, " R6 irq seen"}, ok, 1);
        chk({tag, " R9 sdo bits"}, got, txb);
        rd(2'd0, r); chk({tag, " R9 received"}, r, rxb);
    endtask

    initial begin
        logic [7:0] r, got;
        bit ok;
        int b, l0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        rd(2'd1, r); chk("R1 control reset", r, 0);
        rd(2'd2, r); chk("R1 status reset", r, 0);
        chk("R1 sck_o reset", sck_o, 0);
        chk("R1 sdo_oe reset", sdo_oe, 0);
        chk("R1 irq reset", irq_o, 0);

        wr(2'd2, 8'hFF); rd(2'd2, r); chk("R12 status writable bits", r, 8'hC0);
        rd(2'd3, r); chk("R12 address 3", r, 0);
        wr(2'd2, 8'h00);

        // R2: disabled port
        wr(2'd1, 8'h00); b = irq_cnt; l0 = lead_cnt;
        wr(2'd0, 8'h5A); repeat (100) @(negedge clk);
        chk("R2 no irq when disabled", irq_cnt - b, 0);
        chk("R2 no sck when disabled", lead_cnt - l0, 0);
        chk("R2 sdo_oe low", sdo_oe, 0);
        chk("R2 sck_oe low", sck_oe, 0);

        // R3: unassigned mode code
        cfg(4'b1010, 1'b0, 1'b0, 1'b0); b = irq_cnt;
        wr(2'd0, 8'h77); repeat (300) @(negedge clk);
        chk("R3 bad code no irq", irq_cnt - b, 0);
        chk("R3 bad code sck_oe", sck_oe, 0);
        chk("R3 bad code sdo_oe", sdo_oe, 0);

        // directed master, every clock source and phase combination
        m_xfer(4'b0000, 1'b0, 1'b0, 1'b0, 8'h81, "div4 cke0 smp0");
        m_xfer(4'b0001, 1'b1, 1'b1, 1'b0, 8'h3C, "div16 cke1 smp0");
        m_xfer(4'b0010, 1'b0, 1'b1, 1'b1, 8'hA6, "div64 cke1 smp1");
        m_xfer(4'b0011, 1'b1, 1'b0, 1'b1, 8'h5B, "timer cke0 smp1");

        // constrained random master transfers
        for (int k = 0; k < 20; k++) begin
            logic [3:0] m;
            m = 4'($urandom % 4);
            m_xfer(m, 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), "random R4");
        end

        // R7 overflow
        cfg(4'b0000, 1'b0, 1'b1, 1'b0); loop_en = 1'b1;
        b = irq_cnt; wr(2'd0, 8'hC3); wait_irq(b, 500, ok);
        b = irq_cnt; wr(2'd0, 8'h18); wait_irq(b, 500, ok);
        chk("R7 second completion", ok, 1);
        rd(2'd1, r); chk("R7 overflow flag", r[6], 1);
        rd(2'd0, r); chk("R7 older byte kept", r, 8'hC3);
        wr(2'd1, 8'h20); rd(2'd1, r); chk("R8 flags cleared by write", r[7:6], 0);

        // R8 write collision
        cfg(4'b0010, 1'b0, 1'b0, 1'b0);
        b = irq_cnt; wr(2'd0, 8'hE1);
        repeat (20) @(negedge clk);
        wr(2'd0, 8'h1E);
        rd(2'd1, r); chk("R8 collision flag", r[7], 1);
        wait_irq(b, 1000, ok);
        rd(2'd0, r); chk("R8 colliding write ignored", r, 8'hE1);
        wr(2'd1, 8'h00);

        // R9 slave without select control
        s_xfer(4'b0101, 1'b0, 1'b0, 8'hB4, 8'h6D, "slave0101 ckp0");
        s_xfer(4'b0101, 1'b1, 1'b0, 8'h29, 8'hD2, "slave0101 ckp1");
        s_xfer(4'b0100, 1'b0, 1'b1, 8'h47, 8'h9C, "slave0100 cke1");

        // R10 select aborts and resets the slave
        loop_en = 1'b0; sck_i = 1'b0; sel_n = 1'b0;
        cfg(4'b0100, 1'b0, 1'b1, 1'b0);
        wr(2'd0, 8'hA5); b = irq_cnt;
        bang(1'b0, 1'b1, 8'hF0, 4, got);
        sel_n = 1'b1; repeat (4) @(negedge clk);
        chk("R10 sdo_oe released", sdo_oe, 0);
        wr(2'd0, 8'h3C);
        rd(2'd1, r); chk("R10 write accepted after abort", r[7], 0);
        chk("R10 aborted byte no irq", irq_cnt - b, 0);
        sel_n = 1'b0; repeat (4) @(negedge clk);
        chk("R10 sdo_oe restored", sdo_oe, 1);
        bang(1'b0, 1'b1, 8'h96, 8, got);
        wait_irq(b, 50, ok);
        chk("R10 sdo after restart", got, 8'h3C);
        rd(2'd0, r); chk("R10 rx after restart", r, 8'h96);

        // R11 unsupported slave combination
        sck_i = 1'b0; cfg(4'b0101, 1'b0, 1'b1, 1'b0);
        chk("R11 sdo_oe low", sdo_oe, 0);
        b = irq_cnt;
        bang(1'b0, 1'b1, 8'h11, 8, got);
        repeat (10) @(negedge clk);
        chk("R11 no completion", irq_cnt - b, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule